// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs clause-22 management frames towards Ethernet PHYs. A client issues one read or write command carrying a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then produces the management clock and drives the data line bit by bit. On reads it releases the data line and collects the PHY's reply. When the frame is over it pulses a completion strobe, and on reads it presents the gathered word at the same time.

Each frame opens with a lengthened preamble of 40 ones rather than the usual 32. This helps PHYs that need extra clocks to lock onto the bus. On a read the master releases the line for one turnaround slot before the data. On a write it drives the turnaround pattern itself. A write ends with one released slot that still carries a clock pulse. The speed of the management clock is set by a half-period count of system clocks.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low and cmd_busy and cmd_done are low.
- R2: Every frame starts with 40 slots in which mdio_oe is high and mdio_o is 1 at the rising mdc edge.
- R3: After the preamble, the start bits 0 then 1 are sent. Then comes the operation: 1 then 0 for a read (cmd_read=1), or 0 then 1 for a write.
- R4: After the operation bits, the PHY address and then the register address are sent, 5 bits each, most significant bit first.
- R5: A read frame has 71 slots. mdio_oe is low in slots 54 to 70. Slot 54 is the turnaround. The mdio_i values at the end of the high phase of slots 55 to 70 are shifted in from the left, first bit as the most significant, and appear on cmd_rdata.
- R6: A write frame has 73 slots. Slots 54 and 55 drive 1 then 0. Slots 56 to 71 drive cmd_wdata from bit 15 down to bit 0. Slot 72 has mdio_oe low and still carries an mdc pulse.
- R7: mdio_o and mdio_oe change only while mdc is low, never during a high phase.
- R8: Each mdc phase lasts HALF_DIV system clocks. A frame of N slots takes exactly 2*HALF_DIV*N clocks from the edge that accepts the command to the edge that raises cmd_done.
- R9: cmd_start has no effect while cmd_busy is high. The frame in progress continues unchanged, and no further frame follows.
- R10: cmd_done is high for exactly one clock. cmd_busy falls on the same edge, and cmd_rdata holds the read result while cmd_done is high.
- R11: Whenever cmd_busy is low, mdc is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request, accepted when cmd_busy is low |
| cmd_read | input | 1 | 1 for a read frame, 0 for a write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_busy | output | 1 | Frame in progress |
| cmd_done | output | 1 | One-clock completion strobe |
| cmd_rdata | output | 16 | Data collected by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
A wrong slot counter or a wrong latched command shows up on the data line within one slot. It appears as a wrong bit at the next rising mdc edge. If the counter stops at the wrong slot, the frame length is off, and cmd_done comes early or late by a whole number of slots. A phase counter that is wrong bends the mdc high time on the very first pulse. A capture register that shifts on the wrong slot gives a rotated or shifted word on cmd_rdata when cmd_done rises.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    // start(2) + operation(2) + two addresses
    localparam int HDR_SLOTS = 4 + 2 * ADDR_W;
    // released turnaround + data
    localparam int RD_TAIL   = 1 + DATA_W;
    // driven turnaround(2) + data + released closing slot
    localparam int WR_TAIL   = 2 + DATA_W + 1;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_t;

    function automatic int frame_slots(logic rd, int pre);
        return rd ? (pre + HDR_SLOTS + RD_TAIL) : (pre + HDR_SLOTS + WR_TAIL);
    endfunction

    function automatic logic is_rd_data(int slot, int pre);
        return (slot >= pre + HDR_SLOTS + 1) && (slot < pre + HDR_SLOTS + 1 + DATA_W);
    endfunction

    function automatic pin_t frame_bit(cmd_t c, int slot, int pre);
        pin_t              p;
        int                s;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        p.oe  = 1'b1;
        p.val = 1'b1;
        if (slot >= pre) begin
            s = slot - pre;
            if (s < 2) begin
                p.val = (s == 1);
            end else if (s < 4) begin
                p.val = c.rd ? (s == 2) : (s == 3);
            end else if (s < 4 + ADDR_W) begin
                a     = c.phy >> (3 + ADDR_W - s);
                p.val = a[0];
            end else if (s < HDR_SLOTS) begin
                a     = c.regad >> (HDR_SLOTS - 1 - s);
                p.val = a[0];
            end else begin
                s = s - HDR_SLOTS;
                if (c.rd) begin
                    p.oe = 1'b0;
                end else if (s < 2) begin
                    p.val = (s == 0);
                end else if (s < 2 + DATA_W) begin
                    d     = c.wdata >> (DATA_W + 1 - s);
                    p.val = d[0];
                end else begin
                    p.oe = 1'b0;
                end
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fall_tick = run && mdc && (cnt == CNT_LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 40,
    parameter int SLOT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  cmd_t              cmd_in,
    input  logic              fall_tick,
    output logic              busy,
    output logic              done,
    output logic [SLOT_W-1:0] slot,
    output cmd_t              cur,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              last_slot;
    logic [SLOT_W-1:0] slot_nxt;
    pin_t              pin_first;
    pin_t              pin_next;

    assign last_slot = (slot == SLOT_W'(frame_slots(cur.rd, PRE_LEN) - 1));
    assign slot_nxt  = slot + 1'b1;
    assign pin_first = frame_bit(cmd_in, 0, PRE_LEN);
    assign pin_next  = frame_bit(cur, int'(slot_nxt), PRE_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            slot    <= '0;
            cur     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                slot    <= '0;
                cur     <= cmd_in;
                mdio_o  <= pin_first.val;
                mdio_oe <= pin_first.oe;
            end else if (busy && fall_tick) begin
                if (last_slot) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    slot    <= slot_nxt;
                    mdio_o  <= pin_next.val;
                    mdio_oe <= pin_next.oe;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data <= '0;
        end else if (sample) begin
            data <= {data[DATA_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PRE_LEN  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int SLOT_W = $clog2(PRE_LEN + HDR_SLOTS + WR_TAIL);

    logic              accept;
    logic              fall_tick;
    logic              sample;
    logic [SLOT_W-1:0] slot;
    cmd_t              cmd_in;
    cmd_t              cur;

    assign accept = cmd_start && !cmd_busy;
    assign cmd_in = '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (cmd_busy),
        .mdc       (mdc),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd_in    (cmd_in),
        .fall_tick (fall_tick),
        .busy      (cmd_busy),
        .done      (cmd_done),
        .slot      (slot),
        .cur       (cur),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign sample = cmd_busy && fall_tick && cur.rd && is_rd_data(int'(slot), PRE_LEN);

    mdio_rx_shift u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample (sample),
        .bit_in (mdio_i),
        .data   (cmd_rdata)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy,
    input logic done
);
    logic [15:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)      hi_len <= '0;
        else if (mdc) hi_len <= hi_len + 1'b1;
        else          hi_len <= '0;
    end

    a_r7_stable_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_high_width: assert property (@(posedge clk) disable iff (rst)
        ($past(mdc) && !mdc) |-> (hi_len == 16'(HALF_DIV)));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (cmd_busy),
    .done    (cmd_done)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int H   = 2;
    localparam int PRE = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_busy, cmd_done, mdc, mdio_o, mdio_oe;
    logic [15:0] cmd_rdata;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic rec_on = 1'b0;
    int   rec_n = 0;
    logic rec_o  [0:127];
    logic rec_oe [0:127];
    logic exp_o  [0:127];
    logic exp_oe [0:127];
    int   exp_n;

    int   viol = 0;
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(H), .PRE_LEN(PRE)) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        if (rec_on && rec_n < 128) begin
            rec_o[rec_n]  = mdio_o;
            rec_oe[rec_n] = mdio_oe;
            rec_n++;
        end
    end

    // R7 monitor: pin changes during an mdc high phase
    always @(negedge clk) begin
        if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) viol++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put(input logic oe, input logic v);
        exp_oe[exp_n] = oe;
        exp_o[exp_n]  = v;
        exp_n++;
    endtask

    task automatic build(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd);
        exp_n = 0;
        for (int i = 0; i < PRE; i++) put(1'b1, 1'b1);
        put(1'b1, 1'b0); put(1'b1, 1'b1);
        put(1'b1, rd);   put(1'b1, !rd);
        for (int i = 4; i >= 0; i--) put(1'b1, phy[i]);
        for (int i = 4; i >= 0; i--) put(1'b1, rg[i]);
        if (rd) begin
            for (int i = 0; i < 17; i++) put(1'b0, 1'b0);
        end else begin
            put(1'b1, 1'b1); put(1'b1, 1'b0);
            for (int i = 15; i >= 0; i--) put(1'b1, wd[i]);
            put(1'b0, 1'b0);
        end
    endtask

    task automatic phy_respond(input logic [15:0] d);
        repeat (PRE + 15) @(posedge mdc);
        for (int i = 15; i >= 0; i--) begin
            @(posedge mdc);
            #2 mdio_i = d[i];
        end
        @(negedge mdc);
        #2 mdio_i = 1'b1;
    endtask

    task automatic region_check(input int lo, input int hi, input string tag);
        int bad = 0;
        for (int k = lo; k < hi; k++) begin
            if (rec_oe[k] !== exp_oe[k]) bad++;
            else if (exp_oe[k] && rec_o[k] !== exp_o[k]) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] reply,
                             input logic inject);
        int cyc;
        build(rd, phy, rg, wd);
        @(negedge clk);
        rec_n  = 0;
        rec_on = 1'b1;
        viol   = 0;
        cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        cmd_start = 1'b1;
        if (rd) fork phy_respond(reply); join_none
        @(negedge clk);
        cmd_start = 1'b0;
        cyc = 0;
        while (!cmd_done && cyc < 5000) begin
            if (inject && cyc == 100) begin
                cmd_start = 1'b1; cmd_read = !rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
            end else begin
                cmd_start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_start = 1'b0;
        check(cyc == exp_n * 2 * H, "R8 frame length in clocks", cyc, exp_n * 2 * H);
        check(cmd_busy == 1'b0, "R10 busy falls with done", cmd_busy, 0);
        if (rd) check(cmd_rdata == reply, "R5 read data", cmd_rdata, reply);
        @(negedge clk);
        rec_on = 1'b0;
        check(cmd_done == 1'b0, "R10 done one clock", cmd_done, 0);
        check(rec_n == exp_n, "R8 slot count", rec_n, exp_n);
        region_check(0, PRE, "R2 preamble");
        region_check(PRE, PRE + 4, "R3 start and operation");
        region_check(PRE + 4, PRE + 14, "R4 addresses");
        if (rd) region_check(PRE + 14, exp_n, "R5 released tail");
        else    region_check(PRE + 14, exp_n, "R6 write tail");
        check(viol == 0, "R7 pins steady while mdc high", viol, 0);
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe, "R11 idle pins", {mdc, mdio_oe}, 0);
    endtask

    task automatic test_reset;
        check(!mdc && !mdio_oe && !cmd_busy && !cmd_done, "R1 reset state",
              {mdc, mdio_oe, cmd_busy, cmd_done}, 0);
    endtask

    task automatic test_ignore;
        int starts = 0;
        run_frame(1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0, 1'b1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cmd_busy || cmd_done) starts++;
        end
        check(starts == 0, "R9 no frame after ignored start", starts, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_frame(1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h8001, 1'b0);
        run_frame(1'b1, 5'h00, 5'h0A, 16'h0, 16'h7FFE, 1'b0);
        test_ignore();
        run_frame(1'b0, 5'h12, 5'h05, 16'h0000, 16'h0, 1'b0);
        run_frame(1'b1, 5'h0C, 5'h13, 16'h0, 16'hC35A, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule